// File: doc/BRIEF.md
# Load-Use Stall Detector

This block is the decode-stage hazard logic of a five-stage in-order pipeline that already has full result bypassing. Bypassing covers almost every dependence. The one case it cannot cover is an instruction that needs a register written by a load sitting directly ahead of it in the execute stage, because the loaded data only exists after the memory stage. When the block sees that pattern, it freezes the program counter and the fetch/decode register for one cycle. At the same time it inserts an empty slot into the decode/execute register. The consumer then reaches execute one cycle later, and the loaded value can be bypassed to it from the memory/writeback register.

The design contains a small harness around the detector: a program counter, the fetch/decode register, the decode/execute register and the two registers that follow it. The harness exists so that the single inserted slot can be seen moving all the way to writeback. Instruction fields are supplied from outside for the address on `pc`. Each instruction carries a tag that the harness passes along unchanged. Forwarding selects are not part of this block.

Top module: `load_use_guard`

## Requirements
- R1: `bubble` is 1 in a cycle exactly when the decode/execute register holds a load (control bit 1, memory read, set) whose destination is non-zero and equal to the rs or the rt field held in fetch/decode. Control encoding: bit 0 register write, bit 1 memory read, bit 2 memory write, bit 3 branch.
- R2: While `bubble` is 1, `pc_wr_en` and `fd_wr_en` are 0, and at the next edge `pc` and the fetch/decode contents hold. Otherwise both enables are 1 and `pc` advances by 4 at each edge.
- R3: An edge taken while `bubble` is 1 loads the decode/execute register with `ex_valid` = 0 and all four control bits 0.
- R4: A stalled consumer enters decode/execute on the edge after the empty slot. One stall therefore costs exactly one cycle, and `bubble` is never 1 in two consecutive cycles.
- R5: A consumer separated from the load by one or more instructions never stalls.
- R6: A load whose destination is register 0 never stalls, even when a source field of the next instruction is 0.
- R7: An instruction that writes a register but does not read memory never causes a stall.
- R8: For two back-to-back loads where the second uses the first one's destination as a source, exactly one cycle is inserted. A consumer of the second load then stalls again for one cycle.
- R9: A synchronous reset sets `pc` to 0 and empties every pipeline register. In the first cycle after reset, `bubble` is 0 and neither `ex_valid` nor `wb_valid` is set.
- R10: Each fetched instruction appears at the writeback register exactly once, in program order, with its tag, destination and control bits unchanged. An inserted slot appears there with `wb_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| f_tag | input | TAG_W | Tag of the instruction at `pc` |
| f_rs | input | REG_W | First source register of the instruction at `pc` |
| f_rt | input | REG_W | Second source register of the instruction at `pc` |
| f_dst | input | REG_W | Destination register of the instruction at `pc` |
| f_ctrl | input | 4 | Control bits of the instruction at `pc` (encoding in R1) |
| pc | output | PC_W | Fetch address |
| pc_wr_en | output | 1 | Program counter update enable |
| fd_wr_en | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | Stall: an empty slot enters decode/execute |
| ex_valid | output | 1 | Decode/execute holds a real instruction |
| ex_tag | output | TAG_W | Tag in decode/execute |
| ex_ctrl | output | 4 | Control bits in decode/execute |
| wb_valid | output | 1 | Writeback register holds a real instruction |
| wb_tag | output | TAG_W | Tag in the writeback register |
| wb_dst | output | REG_W | Destination in the writeback register |
| wb_ctrl | output | 4 | Control bits in the writeback register |

## Verification
Stall detection and slot insertion can coincide with a second hazard being set up. In back-to-back loads, the stalled instruction is itself a load, and one cycle later it becomes the hazard source for its own consumer. A directed run of load, dependent load, dependent consumer provokes this case. A dense random stream over only four register numbers repeats it many times. The bench judges each cycle against its own schedule model: `bubble` must rise exactly once per such pair, never on two cycles in a row, and the writeback stream must show every tag in order with one empty slot per stall.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Control bits carried with every instruction; bit order is part of the port encoding.
  typedef struct packed {
    logic branch;     // bit 3
    logic mem_write;  // bit 2
    logic mem_read;   // bit 1
    logic reg_write;  // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_NONE = '0;

  // Control word after an optional squash.
  function automatic ctrl_t ctrl_gate(ctrl_t c, logic kill);
    return kill ? CTRL_NONE : c;
  endfunction

  // A load is any instruction that reads data memory.
  function automatic logic ctrl_is_load(ctrl_t c);
    return c.mem_read;
  endfunction

endpackage

// File: rtl/ldu_detect.sv
module ldu_detect
  import ldu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  ctrl_t            ex_ctrl,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  output logic             hazard
);

  // Target register is live (register 0 is hardwired and never produced).
  function automatic logic target_live(logic [REG_W-1:0] tgt);
    return tgt != '0;
  endfunction

  // Either source field of the decoding instruction names the target.
  function automatic logic source_hit(logic [REG_W-1:0] tgt, logic [REG_W-1:0] a,
                                      logic [REG_W-1:0] b);
    return (tgt == a) || (tgt == b);
  endfunction

  logic load_in_ex;
  logic live_tgt;
  logic src_match;

  assign load_in_ex = ctrl_is_load(ex_ctrl);
  assign live_tgt   = target_live(ex_dst);
  assign src_match  = source_hit(ex_dst, dec_rs, dec_rt);
  assign hazard     = load_in_ex && live_tgt && src_match;

  always_comb begin
    if ((load_in_ex === 1'b1) && (ex_dst == '0)) begin
      AST_ZERO_TARGET_QUIET: assert (hazard == 1'b0); // R6
    end
    if (load_in_ex === 1'b0) begin
      AST_NONLOAD_QUIET: assert (hazard == 1'b0); // R7
    end
  end

endmodule

// File: rtl/ldu_fetch.sv
module ldu_fetch #(
  parameter int PC_W    = 16,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  output logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  function automatic logic [PC_W-1:0] pc_next(logic [PC_W-1:0] cur, logic we);
    return we ? cur + STEP_V : cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next(pc, pc_we);
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (pc_we && !$past(rst)) |=> (pc == $past(pc) + STEP_V)); // R2

endmodule

// File: rtl/ldu_decode_reg.sv
module ldu_decode_reg
  import ldu_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [TAG_W-1:0] d_tag,
  input  logic [REG_W-1:0] d_rs,
  input  logic [REG_W-1:0] d_rt,
  input  logic [REG_W-1:0] d_dst,
  input  ctrl_t            d_ctrl,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_tag,
  output logic [REG_W-1:0] q_rs,
  output logic [REG_W-1:0] q_rt,
  output logic [REG_W-1:0] q_dst,
  output ctrl_t            q_ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_rs    <= '0;
      q_rt    <= '0;
      q_dst   <= '0;
      q_ctrl  <= CTRL_NONE;
    end else if (en) begin
      q_valid <= 1'b1;
      q_tag   <= d_tag;
      q_rs    <= d_rs;
      q_rt    <= d_rt;
      q_dst   <= d_dst;
      q_ctrl  <= d_ctrl;
    end
  end

  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q_tag) && $stable(q_rs) && $stable(q_rt) && $stable(q_ctrl))); // R2

endmodule

// File: rtl/ldu_flow_reg.sv
module ldu_flow_reg
  import ldu_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             d_valid,
  input  logic [TAG_W-1:0] d_tag,
  input  logic [REG_W-1:0] d_dst,
  input  ctrl_t            d_ctrl,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_tag,
  output logic [REG_W-1:0] q_dst,
  output ctrl_t            q_ctrl
);

  // Only valid and control are squashed; tag and destination pass as don't-care.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_dst   <= '0;
      q_ctrl  <= CTRL_NONE;
    end else begin
      q_valid <= d_valid && !kill;
      q_tag   <= d_tag;
      q_dst   <= d_dst;
      q_ctrl  <= ctrl_gate(d_ctrl, kill);
    end
  end

  AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!q_valid && (q_ctrl == CTRL_NONE))); // R3

endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
  import ldu_pkg::*;
#(
  parameter int PC_W           = 16,
  parameter int PC_STEP        = 4,
  parameter int TAG_W          = 8,
  parameter int REG_W          = 5,
  parameter int POST_EX_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] f_tag,
  input  logic [REG_W-1:0] f_rs,
  input  logic [REG_W-1:0] f_rt,
  input  logic [REG_W-1:0] f_dst,
  input  logic [3:0]       f_ctrl,
  output logic [PC_W-1:0]  pc,
  output logic             pc_wr_en,
  output logic             fd_wr_en,
  output logic             bubble,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic [3:0]       ex_ctrl,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic [REG_W-1:0] wb_dst,
  output logic [3:0]       wb_ctrl
);

  localparam int EX_IDX = 1;
  localparam int LAST   = EX_IDX + POST_EX_STAGES;

  // Fetch/decode register outputs.
  logic             fd_valid;
  logic [TAG_W-1:0] fd_tag;
  logic [REG_W-1:0] fd_rs;
  logic [REG_W-1:0] fd_rt;
  logic [REG_W-1:0] fd_dst;
  ctrl_t            fd_ctrl;

  // Stages from decode/execute to writeback.
  logic             in_valid [EX_IDX:LAST];
  logic [TAG_W-1:0] in_tag   [EX_IDX:LAST];
  logic [REG_W-1:0] in_dst   [EX_IDX:LAST];
  ctrl_t            in_ctrl  [EX_IDX:LAST];
  logic             st_valid [EX_IDX:LAST];
  logic [TAG_W-1:0] st_tag   [EX_IDX:LAST];
  logic [REG_W-1:0] st_dst   [EX_IDX:LAST];
  ctrl_t            st_ctrl  [EX_IDX:LAST];

  logic stall;

  ldu_detect #(.REG_W(REG_W)) i_detect (
    .ex_ctrl (st_ctrl[EX_IDX]),
    .ex_dst  (st_dst[EX_IDX]),
    .dec_rs  (fd_rs),
    .dec_rt  (fd_rt),
    .hazard  (stall)
  );

  assign pc_wr_en = !stall;
  assign fd_wr_en = !stall;
  assign bubble   = stall;

  ldu_fetch #(.PC_W(PC_W), .PC_STEP(PC_STEP)) i_fetch (
    .clk   (clk),
    .rst   (rst),
    .pc_we (pc_wr_en),
    .pc    (pc)
  );

  ldu_decode_reg #(.TAG_W(TAG_W), .REG_W(REG_W)) i_fd (
    .clk     (clk),
    .rst     (rst),
    .en      (fd_wr_en),
    .d_tag   (f_tag),
    .d_rs    (f_rs),
    .d_rt    (f_rt),
    .d_dst   (f_dst),
    .d_ctrl  (ctrl_t'(f_ctrl)),
    .q_valid (fd_valid),
    .q_tag   (fd_tag),
    .q_rs    (fd_rs),
    .q_rt    (fd_rt),
    .q_dst   (fd_dst),
    .q_ctrl  (fd_ctrl)
  );

  for (genvar k = EX_IDX; k <= LAST; k++) begin : g_stage
    localparam bit IS_EX = (k == EX_IDX);
    if (IS_EX) begin : g_src_fd
      assign in_valid[k] = fd_valid;
      assign in_tag[k]   = fd_tag;
      assign in_dst[k]   = fd_dst;
      assign in_ctrl[k]  = fd_ctrl;
    end else begin : g_src_prev
      assign in_valid[k] = st_valid[k-1];
      assign in_tag[k]   = st_tag[k-1];
      assign in_dst[k]   = st_dst[k-1];
      assign in_ctrl[k]  = st_ctrl[k-1];
    end
    ldu_flow_reg #(.TAG_W(TAG_W), .REG_W(REG_W)) i_reg (
      .clk     (clk),
      .rst     (rst),
      .kill    (IS_EX ? stall : 1'b0),
      .d_valid (in_valid[k]),
      .d_tag   (in_tag[k]),
      .d_dst   (in_dst[k]),
      .d_ctrl  (in_ctrl[k]),
      .q_valid (st_valid[k]),
      .q_tag   (st_tag[k]),
      .q_dst   (st_dst[k]),
      .q_ctrl  (st_ctrl[k])
    );
  end

  assign ex_valid = st_valid[EX_IDX];
  assign ex_tag   = st_tag[EX_IDX];
  assign ex_ctrl  = st_ctrl[EX_IDX];
  assign wb_valid = st_valid[LAST];
  assign wb_tag   = st_tag[LAST];
  assign wb_dst   = st_dst[LAST];
  assign wb_ctrl  = st_ctrl[LAST];

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc))); // R2
  AST_BUBBLE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_valid && (ex_ctrl == 4'b0000))); // R3
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((pc == '0) && !stall && !ex_valid && !wb_valid)); // R9

endmodule

// File: tb/test_load_use_guard.sv
module test_load_use_guard;

  localparam int PC_W  = 16;
  localparam int TAG_W = 8;
  localparam int REG_W = 5;
  localparam int NPROG = 256;
  localparam int NCYC  = 240;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TAG_W-1:0] f_tag = '0;
  logic [REG_W-1:0] f_rs = '0, f_rt = '0, f_dst = '0;
  logic [3:0]       f_ctrl = '0;
  logic [PC_W-1:0]  pc;
  logic             pc_wr_en, fd_wr_en, bubble, ex_valid, wb_valid;
  logic [TAG_W-1:0] ex_tag, wb_tag;
  logic [3:0]       ex_ctrl, wb_ctrl;
  logic [REG_W-1:0] wb_dst;

  always #4 clk = ~clk;

  load_use_guard i_load_use_guard (
    .clk(clk), .rst(rst), .f_tag(f_tag), .f_rs(f_rs), .f_rt(f_rt), .f_dst(f_dst),
    .f_ctrl(f_ctrl), .pc(pc), .pc_wr_en(pc_wr_en), .fd_wr_en(fd_wr_en), .bubble(bubble),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_ctrl(ex_ctrl), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_dst(wb_dst), .wb_ctrl(wb_ctrl)
  );

  // Program image: control encoding bit0 reg write, bit1 mem read, bit2 mem write, bit3 branch.
  logic [3:0]       p_ctrl [NPROG];
  logic [REG_W-1:0] p_rs   [NPROG];
  logic [REG_W-1:0] p_rt   [NPROG];
  logic [REG_W-1:0] p_dst  [NPROG];
  string            p_req  [NPROG];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [3:0] c, input int d, input int s, input int t,
                     input string req);
    p_ctrl[i] = c;
    p_dst[i]  = REG_W'(d);
    p_rs[i]   = REG_W'(s);
    p_rt[i]   = REG_W'(t);
    p_req[i]  = req;
  endtask

  // Stall rule restated: load directly ahead, live target, named by either source.
  function automatic bit exp_hit(int ex_i, int dec_i);
    if (ex_i < 0 || dec_i < 0) return 1'b0;
    if (!p_ctrl[ex_i][1]) return 1'b0;
    if (p_dst[ex_i] == '0) return 1'b0;
    return (p_dst[ex_i] == p_rs[dec_i]) || (p_dst[ex_i] == p_rt[dec_i]);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin : main
    int pc_i, dec_i, ex_i, mem_i, wb_i, idx;
    bit stall_e, prev_stall;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPROG; i++) put(i, 4'b0001, 0, 0, 0, "R1");
    // Directed corner cases.
    put(0,  4'b0011, 1, 2, 0, "R1");  // load r1
    put(1,  4'b0001, 8, 1, 3, "R1");  // uses r1 -> stall
    put(2,  4'b0011, 3, 2, 0, "R5");  // load r3
    put(3,  4'b0001, 9, 5, 6, "R5");  // unrelated
    put(4,  4'b0001, 10, 6, 3, "R5"); // uses r3 at distance 2 -> no stall
    put(5,  4'b0011, 0, 2, 0, "R6");  // load to r0
    put(6,  4'b0001, 11, 0, 0, "R6"); // reads r0 -> no stall
    put(7,  4'b0001, 4, 2, 2, "R7");  // alu writes r4
    put(8,  4'b0001, 12, 4, 4, "R7"); // uses r4 -> no stall
    put(9,  4'b0011, 5, 2, 0, "R8");  // load r5
    put(10, 4'b0011, 6, 5, 0, "R8");  // load r6 based on r5 -> stall
    put(11, 4'b0100, 0, 2, 6, "R8");  // store of r6 -> stall again
    put(12, 4'b0011, 7, 2, 0, "R1");  // load r7
    put(13, 4'b1000, 0, 7, 7, "R1");  // branch reads r7 twice -> one stall
    for (int i = 14; i < NPROG; i++) begin
      int kind;
      kind = int'($urandom_range(0, 3));
      case (kind)
        0, 1: put(i, 4'b0011, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 0, "R1");
        2:    put(i, 4'b0100, 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "R1");
        default: put(i, 4'b0001, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3)), "R1");
      endcase
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: state immediately after the reset edges.
    check("R9", pc == '0, "pc after reset", pc, 0);
    check("R9", ex_valid == 1'b0, "ex_valid after reset", ex_valid, 0);
    check("R9", wb_valid == 1'b0, "wb_valid after reset", wb_valid, 0);
    check("R9", bubble == 1'b0, "bubble after reset", bubble, 0);

    pc_i = 0; dec_i = -1; ex_i = -1; mem_i = -1; wb_i = -1; prev_stall = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (cyc > 0) @(negedge clk);
      stall_e = exp_hit(ex_i, dec_i);
      check(dec_i >= 0 ? p_req[dec_i] : "R1", bubble == stall_e, "bubble", bubble, stall_e);
      check("R2", pc_wr_en == !stall_e, "pc_wr_en", pc_wr_en, !stall_e);
      check("R2", fd_wr_en == !stall_e, "fd_wr_en", fd_wr_en, !stall_e);
      check("R2", pc == PC_W'(pc_i * 4), "pc", pc, pc_i * 4);
      if (prev_stall) check("R4", bubble == 1'b0 || stall_e, "second bubble", bubble, 0);
      check(prev_stall ? "R3" : "R4", ex_valid == (ex_i >= 0), "ex_valid", ex_valid, ex_i >= 0);
      if (ex_i >= 0) begin
        check("R4", ex_tag == TAG_W'(ex_i), "ex_tag", ex_tag, ex_i);
        check("R4", ex_ctrl == p_ctrl[ex_i], "ex_ctrl", ex_ctrl, p_ctrl[ex_i]);
      end else begin
        check("R3", ex_ctrl == 4'b0000, "ex_ctrl of empty slot", ex_ctrl, 0);
      end
      check("R10", wb_valid == (wb_i >= 0), "wb_valid", wb_valid, wb_i >= 0);
      if (wb_i >= 0) begin
        check("R10", wb_tag == TAG_W'(wb_i), "wb_tag", wb_tag, wb_i);
        check("R10", wb_dst == p_dst[wb_i], "wb_dst", wb_dst, p_dst[wb_i]);
        check("R10", wb_ctrl == p_ctrl[wb_i], "wb_ctrl", wb_ctrl, p_ctrl[wb_i]);
      end
      // Present the instruction the design is fetching.
      idx    = int'(pc[9:2]);
      f_tag  = TAG_W'(idx);
      f_rs   = p_rs[idx];
      f_rt   = p_rt[idx];
      f_dst  = p_dst[idx];
      f_ctrl = p_ctrl[idx];
      // Advance the schedule model by one edge.
      wb_i  = mem_i;
      mem_i = ex_i;
      if (stall_e) begin
        ex_i = -1;
      end else begin
        ex_i  = dec_i;
        dec_i = pc_i;
        pc_i  = pc_i + 1;
      end
      prev_stall = stall_e;
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule